// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block resolves a translation-buffer miss by reading one entry from a flat page table held in memory. A miss request carries the virtual page number (VPN) and the kind of access (load, store or instruction fetch). The walker adds the VPN, scaled by the 4-byte entry size, to a table base register. It issues a single-beat read and checks the returned entry for residency and permissions. It then hands back the physical page number (PPN) and rights for a refill, or reports a page fault or a protection fault.

The base register points at the running process's table and is rewritten by software on a context switch. It takes a write only while the walker is idle. The walker handles one miss at a time and shows `busy` for the whole walk. The page offset never passes through the block: the caller joins the returned PPN with its own untouched offset. Default geometry is 40-bit virtual addresses, 16 KiB pages (26-bit VPN, 14-bit offset) and a 36-bit physical space (22-bit PPN).

Top module: `pt_walker`

## Requirements
- R1: After reset `busy`, `memReqValid` and `respValid` are low and the base register holds zero.
- R2: A miss is accepted on a clock edge where `missValid` is high and `busy` is low. `busy` is high from the next cycle through the cycle in which `respValid` is high, and low in the cycle after that.
- R3: The entry address is the base register plus the VPN times 4, modulo 2^MEM_AW. `memReqValid` rises the cycle after acceptance and holds with a stable address until a cycle with `memReqReady` high, after which it drops.
- R4: `memRspValid` is taken only after the request handshake. In the cycle after it is taken, `respValid` is high for exactly one cycle. In that cycle `respPpn` equals entry bits 21:0 and `respRights` equals entry bits 30:29.
- R5: Entry bit 31 is the valid bit. When it is 0, `respPageFault` is high and `respProtFault` is low, whatever the rights and access kind.
- R6: Rights encoding is 00 none, 01 read-only, 10 read/write, 11 read/execute. Access kind is 00 load, 01 store, 10 fetch, 11 reserved. For a valid entry, `respProtFault` is high exactly when the rights do not permit the kind; the reserved kind is never permitted.
- R7: A base register write (`baseWrEn`) is taken only while idle; a write while busy leaves the base unchanged for later walks.
- R8: `missValid` while busy is ignored: no second memory request follows the current walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseWrEn | input | 1 | Write strobe for the table base register |
| baseWrData | input | MEM_AW (36) | New table base address |
| missValid | input | 1 | Miss request present |
| missVpn | input | VPN_W (26) | Virtual page number to translate |
| missKind | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 reserved |
| busy | output | 1 | Walk in progress; new misses are not accepted |
| memReqValid | output | 1 | Entry read request |
| memReqAddr | output | MEM_AW (36) | Byte address of the entry |
| memReqReady | input | 1 | Memory accepts the request |
| memRspValid | input | 1 | Read data present |
| memRspData | input | 32 | Page table entry word |
| respValid | output | 1 | One-cycle result strobe |
| respPpn | output | PPN_W (22) | Physical page number from the entry |
| respRights | output | 2 | Rights field from the entry |
| respPageFault | output | 1 | Entry not resident |
| respProtFault | output | 1 | Access kind not permitted |

## Verification
Each result has a fixed distance from its stimulus. `busy` and `memReqValid` are due one cycle after the accepting edge. `memReqValid` falls one cycle after the ready handshake. `respValid` and its fields are due one cycle after the response edge, and `busy` falls one cycle later. The bench drives every input on a falling edge and steps exactly one rising edge before each check. Each value is therefore read half a period after the edge that should have produced it. Ignored stimuli (a base write or a new miss during a walk) are judged by the address of the next walk and by `memReqValid` staying low after the result.

// File: rtl/walker_pkg.sv
package walker_pkg;
  localparam int ENTRY_W   = 32;
  localparam int VALID_POS = 31;
  localparam int RIGHT_HI  = 30;
  localparam int RIGHT_LO  = 29;
  localparam int ENTRY_SH  = $clog2(ENTRY_W / 8);

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'b00,
    KIND_STORE = 2'b01,
    KIND_FETCH = 2'b10,
    KIND_RSVD  = 2'b11
  } accKind_t;

  typedef enum logic [1:0] {
    PERM_NONE = 2'b00,
    PERM_RO   = 2'b01,
    PERM_RW   = 2'b10,
    PERM_RX   = 2'b11
  } perm_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WAIT = 2'b01,
    ST_RESP = 2'b10
  } walkState_t;

  typedef struct packed {
    logic takeMiss;
    logic takeEntry;
    logic loadBase;
  } walkStrobe_t;
endpackage

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        missValid,
  input  logic        baseWrEn,
  input  logic        memReqReady,
  input  logic        memRspValid,
  output walkStrobe_t strobe,
  output logic        busy,
  output logic        memReqValid,
  output logic        respValid
);
  walkState_t state, stateNext;
  logic       reqDone;

  always_comb begin
    strobe.takeMiss  = (state == ST_IDLE) && missValid;
    strobe.loadBase  = (state == ST_IDLE) && baseWrEn;
    strobe.takeEntry = (state == ST_WAIT) && reqDone && memRspValid;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (strobe.takeMiss)  stateNext = ST_WAIT;
      ST_WAIT: if (strobe.takeEntry) stateNext = ST_RESP;
      ST_RESP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      reqDone <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.takeMiss)
        reqDone <= 1'b0;
      else if (memReqValid && memReqReady)
        reqDone <= 1'b1;
    end
  end

  assign busy        = (state != ST_IDLE);
  assign memReqValid = (state == ST_WAIT) && !reqDone;
  assign respValid   = (state == ST_RESP);
endmodule

// File: rtl/pt_walk_datapath.sv
module pt_walk_datapath
  import walker_pkg::*;
#(
  parameter int VPN_W  = 26,
  parameter int PPN_W  = 22,
  parameter int MEM_AW = 36
) (
  input  logic               clk,
  input  logic               rstN,
  input  walkStrobe_t        strobe,
  input  logic [MEM_AW-1:0]  baseWrData,
  input  logic [VPN_W-1:0]   missVpn,
  input  logic [1:0]         missKind,
  input  logic [ENTRY_W-1:0] memRspData,
  output logic [MEM_AW-1:0]  memReqAddr,
  output logic [PPN_W-1:0]   respPpn,
  output logic [1:0]         respRights,
  output logic               respPageFault,
  output logic               respProtFault
);
  logic [MEM_AW-1:0] baseReg;
  logic [VPN_W-1:0]  vpnReg;
  accKind_t          kindReg;
  logic              validReg;
  perm_t             permReg;
  logic [PPN_W-1:0]  ppnReg;
  logic              allowed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg  <= '0;
      vpnReg   <= '0;
      kindReg  <= KIND_LOAD;
      validReg <= 1'b0;
      permReg  <= PERM_NONE;
      ppnReg   <= '0;
    end else begin
      if (strobe.loadBase) baseReg <= baseWrData;
      if (strobe.takeMiss) begin
        vpnReg  <= missVpn;
        kindReg <= accKind_t'(missKind);
      end
      if (strobe.takeEntry) begin
        validReg <= memRspData[VALID_POS];
        permReg  <= perm_t'(memRspData[RIGHT_HI:RIGHT_LO]);
        ppnReg   <= memRspData[PPN_W-1:0];
      end
    end
  end

  assign memReqAddr = baseReg + (MEM_AW'(vpnReg) << ENTRY_SH);

  always_comb begin
    allowed = 1'b0;
    case (permReg)
      PERM_RO: allowed = (kindReg == KIND_LOAD);
      PERM_RW: allowed = (kindReg == KIND_LOAD) || (kindReg == KIND_STORE);
      PERM_RX: allowed = (kindReg == KIND_LOAD) || (kindReg == KIND_FETCH);
      default: allowed = 1'b0;
    endcase
  end

  assign respPpn       = ppnReg;
  assign respRights    = permReg;
  assign respPageFault = !validReg;
  assign respProtFault = validReg && !allowed;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import walker_pkg::*;
#(
  parameter int VA_W   = 40,
  parameter int OFF_W  = 14,
  parameter int PPN_W  = 22,
  parameter int MEM_AW = 36,
  localparam int VPN_W = VA_W - OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               baseWrEn,
  input  logic [MEM_AW-1:0]  baseWrData,
  input  logic               missValid,
  input  logic [VPN_W-1:0]   missVpn,
  input  logic [1:0]         missKind,
  output logic               busy,
  output logic               memReqValid,
  output logic [MEM_AW-1:0]  memReqAddr,
  input  logic               memReqReady,
  input  logic               memRspValid,
  input  logic [ENTRY_W-1:0] memRspData,
  output logic               respValid,
  output logic [PPN_W-1:0]   respPpn,
  output logic [1:0]         respRights,
  output logic               respPageFault,
  output logic               respProtFault
);
  walkStrobe_t strobe;

  pt_walk_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .missValid(missValid), .baseWrEn(baseWrEn),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .strobe(strobe),
    .busy(busy), .memReqValid(memReqValid), .respValid(respValid)
  );

  pt_walk_datapath #(.VPN_W(VPN_W), .PPN_W(PPN_W), .MEM_AW(MEM_AW)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .baseWrData(baseWrData),
    .missVpn(missVpn), .missKind(missKind), .memRspData(memRspData),
    .memReqAddr(memReqAddr), .respPpn(respPpn), .respRights(respRights),
    .respPageFault(respPageFault), .respProtFault(respProtFault)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int MEM_AW = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              missValid,
  input logic              busy,
  input logic              memReqValid,
  input logic [MEM_AW-1:0] memReqAddr,
  input logic              memReqReady,
  input logic              respValid,
  input logic              respPageFault,
  input logic              respProtFault
);
  // R2
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && !busy) |=> busy);
  // R2
  busy_drops_after_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !busy);
  // R3
  req_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> busy);
  // R3
  req_held_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));
  // R4
  resp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);
  // R5
  fault_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !(respPageFault && respProtFault));
  // R8
  no_req_after_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !memReqValid);
endmodule

bind pt_walker pt_walker_chk #(.MEM_AW(MEM_AW)) chk_i (
  .clk(clk), .rstN(rstN), .missValid(missValid), .busy(busy),
  .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memReqReady(memReqReady),
  .respValid(respValid), .respPageFault(respPageFault),
  .respProtFault(respProtFault)
);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  localparam int MEM_AW = 36;
  localparam int VPN_W  = 26;
  localparam int PPN_W  = 22;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              baseWrEn = 1'b0;
  logic [MEM_AW-1:0] baseWrData = '0;
  logic              missValid = 1'b0;
  logic [VPN_W-1:0]  missVpn = '0;
  logic [1:0]        missKind = 2'b00;
  logic              busy, memReqValid, memReqReady = 1'b0, memRspValid = 1'b0;
  logic [MEM_AW-1:0] memReqAddr;
  logic [31:0]       memRspData = '0;
  logic              respValid, respPageFault, respProtFault;
  logic [PPN_W-1:0]  respPpn;
  logic [1:0]        respRights;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  logic [MEM_AW-1:0] curBase = '0;

  always #5 clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rstN(rstN), .baseWrEn(baseWrEn), .baseWrData(baseWrData),
    .missValid(missValid), .missVpn(missVpn), .missKind(missKind), .busy(busy),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .memRspData(memRspData), .respValid(respValid),
    .respPpn(respPpn), .respRights(respRights), .respPageFault(respPageFault),
    .respProtFault(respProtFault)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkEntry(input bit v, input logic [1:0] rt,
                                          input logic [PPN_W-1:0] ppn);
    return {v, rt, 7'b0, ppn};
  endfunction

  function automatic bit permits(input logic [1:0] rt, input logic [1:0] kind);
    case (rt)
      2'b01:   return kind == 2'b00;
      2'b10:   return kind == 2'b00 || kind == 2'b01;
      2'b11:   return kind == 2'b00 || kind == 2'b10;
      default: return 1'b0;
    endcase
  endfunction

  task automatic writeBase(input logic [MEM_AW-1:0] b);
    @(negedge clk);
    baseWrEn = 1'b1; baseWrData = b;
    @(posedge clk);
    @(negedge clk);
    baseWrEn = 1'b0;
    curBase = b;
  endtask

  // One full walk; poke injects a base write and a second miss while busy.
  task automatic doWalk(input logic [VPN_W-1:0] vpn, input logic [1:0] kind,
                        input logic [31:0] entry, input int delay, input bit poke);
    logic [MEM_AW-1:0] expAddr;
    bit expPf, expProt;
    expAddr = curBase + (MEM_AW'(vpn) << 2);
    expPf   = !entry[31];
    expProt = entry[31] && !permits(entry[30:29], kind);
    @(negedge clk);
    missValid = 1'b1; missVpn = vpn; missKind = kind;
    @(posedge clk);
    @(negedge clk);
    missValid = 1'b0;
    check(busy === 1'b1, "R2 busy after accept", 64'(busy), 64'd1);
    check(memReqValid === 1'b1, "R3 request raised", 64'(memReqValid), 64'd1);
    check(memReqAddr === expAddr, "R3 entry address", 64'(memReqAddr), 64'(expAddr));
    for (int i = 0; i < delay; i++) begin
      if (poke && i == 0) begin
        baseWrEn = 1'b1; baseWrData = 36'hABC0;
        missValid = 1'b1; missVpn = vpn ^ 26'h155; missKind = 2'b00;
      end
      @(posedge clk);
      @(negedge clk);
      baseWrEn = 1'b0; missValid = 1'b0;
      check(memReqValid === 1'b1 && memReqAddr === expAddr, "R3 request held",
            64'(memReqAddr), 64'(expAddr));
    end
    memReqReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    memReqReady = 1'b0;
    check(memReqValid === 1'b0, "R3 request dropped", 64'(memReqValid), 64'd0);
    memRspValid = 1'b1; memRspData = entry;
    @(posedge clk);
    @(negedge clk);
    memRspValid = 1'b0; memRspData = '0;
    check(respValid === 1'b1, "R4 result strobe", 64'(respValid), 64'd1);
    check(respPpn === entry[PPN_W-1:0], "R4 ppn", 64'(respPpn), 64'(entry[PPN_W-1:0]));
    check(respRights === entry[30:29], "R4 rights", 64'(respRights), 64'(entry[30:29]));
    check(respPageFault === expPf, "R5 page fault", 64'(respPageFault), 64'(expPf));
    check(respProtFault === expProt, "R6 protection fault", 64'(respProtFault), 64'(expProt));
    @(posedge clk);
    @(negedge clk);
    check(busy === 1'b0 && respValid === 1'b0, "R2 idle after result",
          64'({busy, respValid}), 64'd0);
    if (poke) begin
      for (int j = 0; j < 3; j++) begin
        check(memReqValid === 1'b0 && busy === 1'b0, "R8 miss while busy ignored",
              64'({busy, memReqValid}), 64'd0);
        @(posedge clk);
        @(negedge clk);
      end
    end
  endtask

  task automatic testReset();
    check(busy === 1'b0, "R1 busy at reset", 64'(busy), 64'd0);
    check(memReqValid === 1'b0, "R1 request at reset", 64'(memReqValid), 64'd0);
    check(respValid === 1'b0, "R1 result at reset", 64'(respValid), 64'd0);
    // R1: base starts at zero, so the address is just vpn*4
    doWalk(26'd5, 2'b00, mkEntry(1'b1, 2'b10, 22'h12345), 0, 1'b0);
  endtask

  task automatic testBaseAndWrap();
    writeBase(36'h1_0000_0000);
    doWalk(26'h3FF_FFFF, 2'b01, mkEntry(1'b1, 2'b10, 22'h3FFFFF), 3, 1'b0);
    writeBase(36'hF_FFFF_FFF0);
    doWalk(26'd8, 2'b10, mkEntry(1'b1, 2'b11, 22'h00001), 1, 1'b0);
  endtask

  task automatic testPageFault();
    // R5: invalid entry faults as non-resident even with rights that forbid the access
    doWalk(26'd77, 2'b01, mkEntry(1'b0, 2'b00, 22'h2AAAA), 0, 1'b0);
    doWalk(26'd78, 2'b00, mkEntry(1'b0, 2'b10, 22'h15555), 2, 1'b0);
  endtask

  task automatic testRightsMatrix();
    // R6: every rights code against every access kind
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 4; k++)
        doWalk(26'(r * 4 + k), 2'(k), mkEntry(1'b1, 2'(r), 22'(r * 16 + k)), 0, 1'b0);
  endtask

  task automatic testBusyIgnore();
    writeBase(36'h0_0040_0000);
    // R7 and R8: base write and new miss during the walk
    doWalk(26'd9, 2'b00, mkEntry(1'b1, 2'b01, 22'h00ABC), 2, 1'b1);
    // R7: next walk still uses the base written while idle
    doWalk(26'd0, 2'b00, mkEntry(1'b1, 2'b01, 22'h00DEF), 0, 1'b0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=<50000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBaseAndWrap();
    testPageFault();
    testRightsMatrix();
    testBusyIgnore();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule